// File: doc/BRIEF.md
# Cascadable Dual 16-bit Counter

This block holds two 16-bit counter channels, a lower one and an upper one, that either run on their own or join into one 32-bit counter. Each channel takes its count clock from one of three sources. The first is a shared free-running prescaler with divisors 1, 4, 16 or 64. The second is a pair of quadrature inputs decoded four times per cycle, which can count up or down. The third applies only to the upper channel: a cascade code makes it follow the lower channel's wrap events.

The lower channel is always the low half and the upper channel is always the high half. The upper channel enters cascade mode when its 4-bit source field holds 15. It then steps up once for every lower overflow and down once for every lower underflow, and it applies each step on the cycle after the wrap. An upper channel in quadrature mode ignores the cascade code and counts its own inputs. Software uses a small register port to load the counters while they are stopped, to set each channel's source field and mode bit, and to set two run bits. The combined 32-bit value is always visible on `count32`.

Top module: `tmr_cascade_pair`

## Requirements
- R1: After reset both counters, both configuration registers and both run bits read zero, and `count32` is zero.
- R2: In internal mode, source codes 0, 1, 2 and 3 advance a running counter by one on every cycle where the shared prescaler's low 0, 2, 4 or 6 bits are all ones. The prescaler is a 6-bit counter that starts at zero when reset is released and increments on every clock.
- R3: A channel in internal mode whose source code is undefined holds its value. Codes 4 to 14 are undefined for both channels, and code 15 is also undefined for the lower channel.
- R4: In quadrature mode (configuration bit 4 set), the pins `{A,B}` follow the up order 00, 10, 11, 01. Each step in that order adds one, each step in the reverse order subtracts one, and a change of both pins at once is ignored. A pin change made before a rising edge shows on the counter after the third rising edge.
- R5: The lower counter wraps from 0xFFFF to 0x0000 when it counts up. It can count down, and so wrap from 0x0000 to 0xFFFF, only in quadrature mode.
- R6: When the upper channel runs with source code 15 in internal mode, it adds one on the cycle after a lower overflow and subtracts one on the cycle after a lower underflow. `count32` is `{upper, lower}`.
- R7: An upper channel whose run bit is clear ignores lower wrap events, and each channel counts only while its own run bit is set.
- R8: An upper channel in quadrature mode ignores source code 15 and counts only its own quadrature inputs.
- R9: A write to a counter address loads the value on the next edge only while that channel's run bit is clear. While the channel runs, the write is ignored.
- R10: Address map: 0 lower count, 1 upper count, 2 lower configuration, 3 upper configuration, 4 run bits (bit 0 lower, bit 1 upper). A configuration value holds the source code in bits 3:0 and the mode bit in bit 4, and other bits read zero. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data for `regAddr` |
| loPhaseA | input | 1 | Lower channel quadrature input A |
| loPhaseB | input | 1 | Lower channel quadrature input B |
| upPhaseA | input | 1 | Upper channel quadrature input A |
| upPhaseB | input | 1 | Upper channel quadrature input B |
| count32 | output | 32 | Combined value, upper half in bits 31:16 |

## Verification
The bench first runs the lower channel on each of the four prescaler codes. This separates a divisor that is wrong from a tick phase that is wrong against the reset-aligned prescaler. Cascade runs approach 0xFFFF from just below, both on the internal clock and on quadrature steps that walk down through zero and back up. These runs separate a carry from a borrow and show the one-cycle delay on the upper half. Further runs repeat the wrap with the upper run bit clear, with the upper channel in quadrature mode, with undefined codes, and with writes made while a channel runs. In each of these the upper half or the loaded value must not change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_LO_CNT = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_UP_CNT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO_CFG = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_UP_CFG = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RUN    = 3'd4;

  // Strobes from the control to the datapath, valid for one cycle.
  typedef struct packed {
    logic loInc;
    logic loDec;
    logic loLoad;
    logic upInc;
    logic upDec;
    logic upCascade;  // upper follows lower wrap pulses this cycle
    logic upLoad;
  } tmrStrobes_t;

endpackage

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic phaseA,
  input  logic phaseB,
  output logic stepUp,
  output logic stepDn
);

  logic [1:0] syncQ [SYNC_STAGES];
  logic [1:0] lastQ;
  logic [1:0] curAb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= 2'b00;
      lastQ <= 2'b00;
    end else begin
      syncQ[0] <= {phaseA, phaseB};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      lastQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign curAb = syncQ[SYNC_STAGES-1];

  // Up order of {A,B}: 00 -> 10 -> 11 -> 01 -> 00
  always_comb begin
    stepUp = 1'b0;
    stepDn = 1'b0;
    case ({lastQ, curAb})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: stepUp = 1'b1;
      4'b1000, 4'b1110, 4'b0111, 4'b0001: stepDn = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 4,
  parameter int CASC_SEL    = 15,
  parameter int PRE_STEPS   = 4,
  parameter int PRE_SHIFT   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [SEL_W:0]    cfgWrData,
  input  logic              loPhaseA,
  input  logic              loPhaseB,
  input  logic              upPhaseA,
  input  logic              upPhaseB,
  input  logic [CNT_W-1:0]  loCnt,
  input  logic [CNT_W-1:0]  upCnt,
  output tmrStrobes_t       strb,
  output logic [CNT_W-1:0]  regRdData
);

  localparam int NCH   = 2;
  localparam int PRE_W = PRE_SHIFT * (PRE_STEPS - 1);

  logic [PRE_W-1:0]            preCnt;
  logic [NCH-1:0]              chRun;
  logic [NCH-1:0][SEL_W-1:0]   chSel;
  logic [NCH-1:0]              chPhase;
  logic [NCH-1:0]              ownInc;
  logic [NCH-1:0]              ownDec;
  logic [NCH-1:0]              phA;
  logic [NCH-1:0]              phB;

  assign phA = {upPhaseA, loPhaseA};
  assign phB = {upPhaseB, loPhaseB};

  function automatic logic [PRE_W-1:0] tickMask(input int s);
    return PRE_W'((1 << (PRE_SHIFT * s)) - 1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              chRun <= '0;
    else if (regWrEn && regAddr == ADDR_RUN) chRun <= cfgWrData[NCH-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : gChan
    logic [SEL_W-1:0] selQ;
    logic             phaseQ;
    logic             tick;
    logic             qUp;
    logic             qDn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ   <= '0;
        phaseQ <= 1'b0;
      end else if (regWrEn && regAddr == ADDR_LO_CFG + ADDR_W'(g)) begin
        selQ   <= cfgWrData[SEL_W-1:0];
        phaseQ <= cfgWrData[SEL_W];
      end
    end

    tmr_quad_dec #(.SYNC_STAGES(SYNC_STAGES)) uQuad (
      .clk    (clk),
      .rstN   (rstN),
      .phaseA (phA[g]),
      .phaseB (phB[g]),
      .stepUp (qUp),
      .stepDn (qDn)
    );

    always_comb begin
      tick = 1'b0;
      for (int s = 0; s < PRE_STEPS; s++) begin
        if (selQ == SEL_W'(s) && ((preCnt & tickMask(s)) == tickMask(s))) tick = 1'b1;
      end
    end

    assign chSel[g]   = selQ;
    assign chPhase[g] = phaseQ;
    assign ownInc[g]  = chRun[g] & (phaseQ ? qUp : tick);
    assign ownDec[g]  = chRun[g] & phaseQ & qDn;
  end

  always_comb begin
    strb           = '0;
    strb.loInc     = ownInc[0];
    strb.loDec     = ownDec[0];
    strb.upInc     = ownInc[1];
    strb.upDec     = ownDec[1];
    strb.upCascade = chRun[1] & ~chPhase[1] & (chSel[1] == SEL_W'(CASC_SEL));
    strb.loLoad    = regWrEn & (regAddr == ADDR_LO_CNT) & ~chRun[0];
    strb.upLoad    = regWrEn & (regAddr == ADDR_UP_CNT) & ~chRun[1];
  end

  always_comb begin
    case (regAddr)
      ADDR_LO_CNT: regRdData = loCnt;
      ADDR_UP_CNT: regRdData = upCnt;
      ADDR_LO_CFG: regRdData = CNT_W'({chPhase[0], chSel[0]});
      ADDR_UP_CFG: regRdData = CNT_W'({chPhase[1], chSel[1]});
      ADDR_RUN:    regRdData = CNT_W'(chRun);
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strb,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] loCnt,
  output logic [CNT_W-1:0] upCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic carryQ;
  logic borrowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ  <= 1'b0;
      borrowQ <= 1'b0;
    end else begin
      carryQ  <= strb.loInc & (loCnt == CNT_MAX);
      borrowQ <= strb.loDec & (loCnt == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           loCnt <= '0;
    else if (strb.loLoad) loCnt <= loadData;
    else if (strb.loInc)  loCnt <= loCnt + 1'b1;
    else if (strb.loDec)  loCnt <= loCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          upCnt <= '0;
    else if (strb.upLoad)                upCnt <= loadData;
    else if (strb.upCascade && carryQ)   upCnt <= upCnt + 1'b1;
    else if (strb.upCascade && borrowQ)  upCnt <= upCnt - 1'b1;
    else if (strb.upInc)                 upCnt <= upCnt + 1'b1;
    else if (strb.upDec)                 upCnt <= upCnt - 1'b1;
  end

endmodule

// File: rtl/tmr_cascade_pair.sv
module tmr_cascade_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 4,
  parameter int CASC_SEL    = 15,
  parameter int PRE_STEPS   = 4,
  parameter int PRE_SHIFT   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic               regWrEn,
  input  logic [CNT_W-1:0]   regWrData,
  output logic [CNT_W-1:0]   regRdData,
  input  logic               loPhaseA,
  input  logic               loPhaseB,
  input  logic               upPhaseA,
  input  logic               upPhaseB,
  output logic [2*CNT_W-1:0] count32
);

  tmrStrobes_t      strb;
  logic [CNT_W-1:0] loCnt;
  logic [CNT_W-1:0] upCnt;

  tmr_ctrl #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .CASC_SEL(CASC_SEL),
    .PRE_STEPS(PRE_STEPS), .PRE_SHIFT(PRE_SHIFT), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .cfgWrData (regWrData[SEL_W:0]),
    .loPhaseA  (loPhaseA),
    .loPhaseB  (loPhaseB),
    .upPhaseA  (upPhaseA),
    .upPhaseB  (upPhaseB),
    .loCnt     (loCnt),
    .upCnt     (upCnt),
    .strb      (strb),
    .regRdData (regRdData)
  );

  tmr_dpath #(.CNT_W(CNT_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadData (regWrData),
    .loCnt    (loCnt),
    .upCnt    (upCnt)
  );

  assign count32 = {upCnt, loCnt};

endmodule

// File: rtl/tmr_cascade_pair_chk.sv
module tmr_cascade_pair_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input tmrStrobes_t      strb,
  input logic [CNT_W-1:0] loCnt,
  input logic [CNT_W-1:0] upCnt,
  input logic [CNT_W-1:0] regWrData
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  // R1: counters held at zero while reset is asserted
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (loCnt == '0 && upCnt == '0)
        else $error("a_r1_reset_clear");
    end
  end

  // R9: a permitted load lands on the next edge
  a_r9_load_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.loLoad |=> loCnt == $past(regWrData));

  // R5: the lower counter moves by at most one per cycle
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loLoad |=> (loCnt == $past(loCnt) || loCnt == $past(loCnt) + 1'b1 ||
                      loCnt == $past(loCnt) - 1'b1));

  // R6: overflow of the lower half reaches the upper half one cycle later
  a_r6_carry_applied: assert property (@(posedge clk) disable iff (!rstN)
    (strb.upCascade && !strb.upLoad && $past(strb.loInc) && $past(loCnt) == ALL_ONES)
      |=> upCnt == $past(upCnt) + 1'b1);

  // R6: underflow of the lower half reaches the upper half one cycle later
  a_r6_borrow_applied: assert property (@(posedge clk) disable iff (!rstN)
    (strb.upCascade && !strb.upLoad && $past(strb.loDec) && $past(loCnt) == '0)
      |=> upCnt == $past(upCnt) - 1'b1);

  // R5: the lower counter never steps both ways at once
  a_r5_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loInc, strb.loDec}));

endmodule

bind tmr_cascade_pair tmr_cascade_pair_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .loCnt     (loCnt),
  .upCnt     (upCnt),
  .regWrData (regWrData)
);

// File: tb/tmr_cascade_pair_tb.sv
module tmr_cascade_pair_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        loPhaseA = 1'b0, loPhaseB = 1'b0, upPhaseA = 1'b0, upPhaseB = 1'b0;
  logic [31:0] count32;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    finished = 0;
  string curReq = "R1";
  int    qPos [2] = '{0, 0};

  // reference model state
  logic [15:0] mLo, mUp;
  bit          mCarry, mBorrow;
  int          mPre;
  logic [1:0]  mRun;
  logic [3:0]  mSel [2];
  bit          mPh [2];
  logic [1:0]  mD1 [2], mD2 [2], mD3 [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_cascade_pair dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .loPhaseA(loPhaseA), .loPhaseB(loPhaseB),
    .upPhaseA(upPhaseA), .upPhaseB(upPhaseB), .count32(count32)
  );

  function automatic int grayPos(input logic [1:0] v);
    case (v)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] grayVal(input int p);
    case (p & 3)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic int quadDir(input logic [1:0] prev, input logic [1:0] cur);
    int d;
    d = (grayPos(cur) - grayPos(prev) + 4) % 4;
    if (d == 1) return 1;
    if (d == 3) return -1;
    return 0;
  endfunction

  function automatic int prescaleStep(input logic [3:0] sel, input int pre);
    int mask;
    if (sel > 4'd3) return 0;
    mask = (1 << (2 * int'(sel))) - 1;
    return ((pre & mask) == mask) ? 1 : 0;
  endfunction

  function automatic logic [15:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mLo;
      3'd1: return mUp;
      3'd2: return {11'b0, mPh[0], mSel[0]};
      3'd3: return {11'b0, mPh[1], mSel[1]};
      3'd4: return {14'b0, mRun};
      default: return 16'h0;
    endcase
  endfunction

  // behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    int dq [2];
    int stLo, stUp;
    bit nc, nb;
    if (!rstN) begin
      mLo = 0; mUp = 0; mCarry = 0; mBorrow = 0; mPre = 0; mRun = 0;
      for (int c = 0; c < 2; c++) begin
        mSel[c] = 0; mPh[c] = 0; mD1[c] = 0; mD2[c] = 0; mD3[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) dq[c] = quadDir(mD3[c], mD2[c]);
      stLo = 0;
      stUp = 0;
      if (mRun[0]) stLo = mPh[0] ? dq[0] : prescaleStep(mSel[0], mPre);
      if (mRun[1]) begin
        if (mPh[1])              stUp = dq[1];
        else if (mSel[1] == 15)  stUp = mCarry ? 1 : (mBorrow ? -1 : 0);
        else                     stUp = prescaleStep(mSel[1], mPre);
      end
      nc = (stLo == 1) && (mLo == 16'hFFFF);
      nb = (stLo == -1) && (mLo == 16'h0000);
      mLo = mLo + 16'(stLo);
      mUp = mUp + 16'(stUp);
      if (regWrEn) begin
        case (regAddr)
          3'd0: if (!mRun[0]) mLo = regWrData;
          3'd1: if (!mRun[1]) mUp = regWrData;
          3'd2: begin mSel[0] = regWrData[3:0]; mPh[0] = regWrData[4]; end
          3'd3: begin mSel[1] = regWrData[3:0]; mPh[1] = regWrData[4]; end
          3'd4: mRun = regWrData[1:0];
          default: ;
        endcase
      end
      mCarry = nc;
      mBorrow = nb;
      mPre = (mPre + 1) % 64;
      for (int c = 0; c < 2; c++) begin
        mD3[c] = mD2[c];
        mD2[c] = mD1[c];
      end
      mD1[0] = {loPhaseA, loPhaseB};
      mD1[1] = {upPhaseA, upPhaseB};
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      checks++;
      if (count32 !== {mUp, mLo}) begin
        fails++;
        $display("FAIL %s: count32 actual %h expected %h at cycle %0d",
                 curReq, count32, {mUp, mLo}, cycles);
      end
      if (cycles > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog: actual cycle %0d expected below %0d", cycles, WATCHDOG);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkRead(input logic [2:0] a);
    @(negedge clk);
    regAddr = a;
    #1;
    checks++;
    if (regRdData !== expRead(a)) begin
      fails++;
      $display("FAIL %s: read addr %0d actual %h expected %h", curReq, a, regRdData, expRead(a));
    end
  endtask

  task automatic qMove(input int ch, input int delta);
    logic [1:0] v;
    @(negedge clk);
    qPos[ch] = (qPos[ch] + delta + 4) % 4;
    v = grayVal(qPos[ch]);
    if (ch == 0) {loPhaseA, loPhaseB} = v;
    else         {upPhaseA, upPhaseB} = v;
    idle(3);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;

    // R1 and R10: reset state through the register port
    curReq = "R1";
    for (int a = 0; a < 8; a++) chkRead(3'(a));

    // R2: lower channel on every prescale divisor
    curReq = "R2";
    wr(3'd2, 16'h0000);
    wr(3'd4, 16'h0001);
    idle(20);
    wr(3'd2, 16'h0001); idle(40);
    wr(3'd2, 16'h0002); idle(100);
    wr(3'd2, 16'h0003); idle(300);
    curReq = "R10";
    chkRead(3'd2);
    chkRead(3'd4);

    // R3: undefined codes hold the counter, code 15 on the lower channel too
    curReq = "R3";
    wr(3'd2, 16'h0005); idle(80);
    wr(3'd2, 16'h000F); idle(80);

    // R9: writes ignored while running, accepted while stopped
    curReq = "R9";
    wr(3'd0, 16'h1234); idle(2);
    chkRead(3'd0);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'hFFF0);
    wr(3'd1, 16'h00A0);
    chkRead(3'd0);
    chkRead(3'd1);

    // R6: cascade on the internal clock across a lower overflow
    curReq = "R6";
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h000F);
    wr(3'd4, 16'h0003);
    idle(40);
    curReq = "R9";
    wr(3'd1, 16'h5555); idle(2);
    chkRead(3'd1);

    // R7: upper stopped ignores wrap pulses; stopped lower does not count
    curReq = "R7";
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'hFFFC);
    wr(3'd4, 16'h0001);
    idle(20);
    wr(3'd4, 16'h0002);
    idle(30);

    // R4, R5, R6: quadrature lower channel walks down through zero and back
    curReq = "R4";
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h0005);
    wr(3'd2, 16'h0010);
    wr(3'd4, 16'h0003);
    qMove(0, 1); qMove(0, 1);
    curReq = "R5";
    for (int i = 0; i < 5; i++) qMove(0, -1);
    curReq = "R6";
    for (int i = 0; i < 4; i++) qMove(0, 1);
    curReq = "R4";
    qMove(0, 2);                 // both pins change: ignored
    qMove(0, -1);
    chkRead(3'd0);

    // R8: upper in quadrature mode ignores code 15
    curReq = "R8";
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'hFFF8);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h001F);
    wr(3'd4, 16'h0003);
    idle(30);
    qMove(1, 1); qMove(1, 1); qMove(1, -1);
    chkRead(3'd3);

    idle(5);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule